// File: doc/BRIEF.md
# Two-Phase Reseeding Pattern Generator

This block expands compressed test data into scan patterns using a linear feedback shift register whose state runs on from one vector to the next. Tester interaction and scan loading happen in separate phases. In the reseed phase, the register advances once per tester tick and XORs a tester bit into its feedback, while the scan chain holds its contents. In the load phase, the register advances once per scan tick and drives the chain, with no tester input. The two phases have their own rate enables, so the load phase can run at a faster scan rate while the whole block stays in one clock domain.

A run begins on a start pulse. The block latches two programmed counts: a number of pseudorandom patterns and a number of deterministic vectors. The pseudorandom patterns come first. In these, the register runs autonomously and shifts the chain, which gives mixed-mode self-test. Each deterministic vector then takes one reseed phase and one load phase. Every pattern ends with a single capture cycle. The phase sequence is IDLE → PRNG (repeated) → (RESEED → LOAD → CAPTURE) repeated → DONE. A pseudorandom pattern is PRNG followed by CAPTURE. When the injection length equals the register width, the tester bits can force any register state, which is the same as a full static reseed.

The named transitions are:
- IDLE/DONE to PRNG, RESEED or DONE on start.
- PRNG to CAPTURE after the last shift.
- RESEED to LOAD after the last injection.
- LOAD to CAPTURE after the last shift.
- CAPTURE to PRNG, RESEED or DONE, depending on the counts remaining.

Top module: `preload_reseed_gen`

## Requirements
- R1: While reset is held and after its release without start, `phase` is 0 (IDLE), and `scan_shift`, `capture` and `done` are low, and `pattern_cnt` is 0.
- R2: The phase codes are IDLE=0, PRNG=1, RESEED=2, LOAD=3, CAPTURE=4 and DONE=5. A start in IDLE or DONE reloads the register with SEED (default 16'hACE1) and clears `pattern_cnt`. The next phase is PRNG if the pseudorandom count is non-zero, otherwise RESEED if the vector count is non-zero, otherwise DONE.
- R3: In PRNG, every cycle with `scan_tick` high gives one autonomous register step and one scan shift (`scan_shift` high). After SCAN_LEN shifts the block moves to CAPTURE. Tester inputs have no effect.
- R4: In RESEED, every cycle with `tester_tick` high gives one register step with `tester_bit` XORed into the feedback. After exactly INJ_LEN such steps the block moves to LOAD. `scan_shift` stays low whatever `scan_tick` does.
- R5: In LOAD, every cycle with `scan_tick` high gives one autonomous step and one scan shift. After SCAN_LEN shifts the block moves to CAPTURE. `tester_bit` and `tester_tick` have no effect.
- R6: CAPTURE lasts one cycle, raises `capture` and adds one to `pattern_cnt`. From CAPTURE the block goes to PRNG while pseudorandom patterns remain, else to RESEED while vectors remain, else to DONE.
- R7: The register is not reloaded between patterns. Each reseed acts on the state left by the previous pattern.
- R8: With INJ_LEN equal to the register width, a suitable choice of injected bits reaches any target state. The first SCAN_LEN bits of the next load then equal target bits 0, 1, 2 and so on in that order.
- R9: One register step computes next = {XOR(state & TAPS) ^ inj, state[W-1:1]}, where inj is `tester_bit` in RESEED and 0 otherwise. `scan_out` is state bit 0 and is the value the chain takes on each shift. The default TAPS is 16'h002D.
- R10: DONE holds with `done` high and `pattern_cnt` equal to the sum of the two counts until the next start, which begins a new run.
- R11: The two count inputs are sampled only at start. Changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when in IDLE or DONE |
| prng_count | input | CNT_W | Number of pseudorandom patterns |
| det_count | input | CNT_W | Number of deterministic vectors |
| tester_tick | input | 1 | Rate enable for the reseed phase |
| tester_bit | input | 1 | Serial bit injected into the feedback |
| scan_tick | input | 1 | Rate enable for scan shifting |
| scan_out | output | 1 | Serial data into the scan chain |
| scan_shift | output | 1 | Scan enable: the chain shifts this cycle |
| capture | output | 1 | One-cycle capture strobe |
| phase | output | 3 | Current phase code |
| pattern_cnt | output | CNT_W+1 | Patterns completed in this run |
| done | output | 1 | Run complete |

## Verification
The assertions assume that `start` is pulsed only in IDLE or DONE. They also assume that each rate enable is a plain level sampled at the clock edge, so one step is taken per cycle in which the enable is high.

The directed stimulus drives every input one nanosecond after the rising edge. It toggles the rate enables and tester bit from a bench-side pseudorandom source, including in phases where they must be ignored. It raises start only after the block reports IDLE or DONE. A bench model of the register, advanced from the observed phase and the driven enables, predicts every scan bit.

// File: rtl/reseed_pkg.sv
package reseed_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PRNG    = 3'd1,
        PH_RESEED  = 3'd2,
        PH_LOAD    = 3'd3,
        PH_CAPTURE = 3'd4,
        PH_DONE    = 3'd5
    } phase_e;

    function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/reseed_lfsr.sv
module reseed_lfsr #(
    parameter int unsigned    W    = 16,
    parameter logic [W-1:0]   TAPS = 16'h002D,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         inj_en,
    input  logic         inj_bit,
    output logic [W-1:0] state,
    output logic         out_bit
);

    logic [W-1:0] tapped;
    logic         feedback;
    logic [W-1:0] state_nx;

    for (genvar g = 0; g < W; g++) begin : g_tap
        if (TAPS[g]) begin : g_on
            assign tapped[g] = state[g];
        end else begin : g_off
            assign tapped[g] = 1'b0;
        end
    end

    always_comb begin
        feedback = (^tapped) ^ (inj_en & inj_bit);
        state_nx = {feedback, state[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEED;
        else if (load)
            state <= SEED;
        else if (step)
            state <= state_nx;
    end

    assign out_bit = state[0];

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(state)); // R7

    AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (state[W-2:0] == $past(state[W-1:1]))); // R9

endmodule

// File: rtl/reseed_phase_fsm.sv
module reseed_phase_fsm
    import reseed_pkg::*;
#(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned INJ_LEN  = 6,
    parameter int unsigned SCAN_LEN = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] prng_count,
    input  logic [CNT_W-1:0] det_count,
    input  logic             tester_tick,
    input  logic             scan_tick,
    output phase_e           phase,
    output logic             lfsr_load,
    output logic             lfsr_step,
    output logic             lfsr_inj,
    output logic             scan_shift,
    output logic             capture,
    output logic [CNT_W:0]   pattern_cnt,
    output logic             done
);

    localparam int unsigned MAXL   = larger_of(INJ_LEN, SCAN_LEN);
    localparam int unsigned STEP_W = $clog2(MAXL + 1);
    localparam logic [STEP_W-1:0] LAST_SHIFT = STEP_W'(SCAN_LEN - 1);
    localparam logic [STEP_W-1:0] LAST_INJ   = STEP_W'(INJ_LEN - 1);

    phase_e             state, state_nx;
    logic [STEP_W-1:0]  step_cnt;
    logic [CNT_W-1:0]   prng_left;
    logic [CNT_W-1:0]   det_left;
    logic               shift_end;
    logic               inj_end;
    logic               launch;

    // next-state logic
    always_comb begin
        shift_end = scan_tick && (step_cnt == LAST_SHIFT);
        inj_end   = tester_tick && (step_cnt == LAST_INJ);
        launch    = start && (state == PH_IDLE || state == PH_DONE);
        state_nx  = state;
        unique case (state)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    if (prng_count != '0)
                        state_nx = PH_PRNG;
                    else if (det_count != '0)
                        state_nx = PH_RESEED;
                    else
                        state_nx = PH_DONE;
                end
            end
            PH_PRNG: begin
                if (shift_end)
                    state_nx = PH_CAPTURE;
            end
            PH_RESEED: begin
                if (inj_end)
                    state_nx = PH_LOAD;
            end
            PH_LOAD: begin
                if (shift_end)
                    state_nx = PH_CAPTURE;
            end
            PH_CAPTURE: begin
                if (prng_left != '0)
                    state_nx = PH_PRNG;
                else if (det_left != '0)
                    state_nx = PH_RESEED;
                else
                    state_nx = PH_DONE;
            end
            default: state_nx = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PH_IDLE;
        else
            state <= state_nx;
    end

    // step and pattern bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt    <= '0;
            prng_left   <= '0;
            det_left    <= '0;
            pattern_cnt <= '0;
        end else begin
            if (state_nx != state)
                step_cnt <= '0;
            else if (lfsr_step)
                step_cnt <= step_cnt + 1'b1;

            if (launch) begin
                prng_left   <= prng_count;
                det_left    <= det_count;
                pattern_cnt <= '0;
            end
            if (state == PH_PRNG && shift_end)
                prng_left <= prng_left - 1'b1;
            if (state == PH_LOAD && shift_end)
                det_left <= det_left - 1'b1;
            if (state == PH_CAPTURE)
                pattern_cnt <= pattern_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        phase      = state;
        scan_shift = 1'b0;
        lfsr_inj   = 1'b0;
        capture    = 1'b0;
        done       = 1'b0;
        unique case (state)
            PH_PRNG, PH_LOAD: scan_shift = scan_tick;
            PH_RESEED:        lfsr_inj   = 1'b1;
            PH_CAPTURE:       capture    = 1'b1;
            PH_DONE:          done       = 1'b1;
            default: ;
        endcase
        lfsr_step = scan_shift | (lfsr_inj & tester_tick);
        lfsr_load = launch;
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (step_cnt < STEP_W'(MAXL))); // R5

    AST_RESEED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RESEED) |=> (state == PH_RESEED || state == PH_LOAD)); // R4

    AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOAD && $past(state) != PH_LOAD) |-> ($past(state) == PH_RESEED)); // R4

    AST_CAPTURE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CAPTURE) |-> $past(scan_shift)); // R3

    AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (pattern_cnt == (CNT_W+1)'($past(pattern_cnt) + 1'b1))); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DONE && !start) |=> (state == PH_DONE && $stable(pattern_cnt))); // R10

endmodule

// File: rtl/preload_reseed_gen.sv
module preload_reseed_gen
    import reseed_pkg::*;
#(
    parameter int unsigned          W        = 16,
    parameter logic [W-1:0]         TAPS     = 16'h002D,
    parameter logic [W-1:0]         SEED     = 16'hACE1,
    parameter int unsigned          INJ_LEN  = 6,
    parameter int unsigned          SCAN_LEN = 20,
    parameter int unsigned          CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] prng_count,
    input  logic [CNT_W-1:0] det_count,
    input  logic             tester_tick,
    input  logic             tester_bit,
    input  logic             scan_tick,
    output logic             scan_out,
    output logic             scan_shift,
    output logic             capture,
    output logic [2:0]       phase,
    output logic [CNT_W:0]   pattern_cnt,
    output logic             done
);

    phase_e       ph;
    logic         lfsr_load;
    logic         lfsr_step;
    logic         lfsr_inj;
    logic [W-1:0] lfsr_state;

    reseed_phase_fsm #(
        .CNT_W    (CNT_W),
        .INJ_LEN  (INJ_LEN),
        .SCAN_LEN (SCAN_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .prng_count  (prng_count),
        .det_count   (det_count),
        .tester_tick (tester_tick),
        .scan_tick   (scan_tick),
        .phase       (ph),
        .lfsr_load   (lfsr_load),
        .lfsr_step   (lfsr_step),
        .lfsr_inj    (lfsr_inj),
        .scan_shift  (scan_shift),
        .capture     (capture),
        .pattern_cnt (pattern_cnt),
        .done        (done)
    );

    reseed_lfsr #(
        .W    (W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lfsr_load),
        .step    (lfsr_step),
        .inj_en  (lfsr_inj),
        .inj_bit (tester_bit),
        .state   (lfsr_state),
        .out_bit (scan_out)
    );

    assign phase = ph;

    AST_NO_SHIFT_IN_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2) |-> !scan_shift); // R4

    AST_RELOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (phase == 3'd0 || phase == 3'd5)) |=> (lfsr_state == SEED)); // R2

endmodule

// File: tb/tb_preload_reseed_gen.sv
module tb_preload_reseed_gen;

    localparam int unsigned W     = 16;
    localparam logic [W-1:0] TAPS = 16'h002D;
    localparam logic [W-1:0] SEED = 16'hACE1;
    localparam int unsigned N     = 6;
    localparam int unsigned M     = 20;
    localparam int unsigned CW    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [CW-1:0] prng_count = '0;
    logic [CW-1:0] det_count  = '0;
    logic          tester_tick = 1'b0;
    logic          tester_bit  = 1'b0;
    logic          scan_tick   = 1'b1;
    logic          scan_out, scan_shift, capture, done;
    logic [2:0]    phase;
    logic [CW:0]   pattern_cnt;

    preload_reseed_gen #(.W(W), .TAPS(TAPS), .SEED(SEED), .INJ_LEN(N),
                         .SCAN_LEN(M), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .prng_count(prng_count),
        .det_count(det_count), .tester_tick(tester_tick), .tester_bit(tester_bit),
        .scan_tick(scan_tick), .scan_out(scan_out), .scan_shift(scan_shift),
        .capture(capture), .phase(phase), .pattern_cnt(pattern_cnt), .done(done));

    // full-width injection instance
    logic          f_start = 1'b0;
    logic          f_tick  = 1'b0;
    logic          f_bit   = 1'b0;
    logic          f_out, f_shift, f_cap, f_done;
    logic [2:0]    f_phase;
    logic [CW:0]   f_cnt;

    preload_reseed_gen #(.W(W), .TAPS(TAPS), .SEED(SEED), .INJ_LEN(W),
                         .SCAN_LEN(W), .CNT_W(CW)) dut_full (
        .clk(clk), .rst_n(rst_n), .start(f_start), .prng_count(CW'(1)),
        .det_count(CW'(2)), .tester_tick(f_tick), .tester_bit(f_bit),
        .scan_tick(1'b1), .scan_out(f_out), .scan_shift(f_shift),
        .capture(f_cap), .phase(f_phase), .pattern_cnt(f_cnt), .done(f_done));

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mstep(input logic [W-1:0] s, input logic inj);
        return {(^(s & TAPS)) ^ inj, s[W-1:1]};
    endfunction

    // pseudorandom input noise
    logic noise_en = 1'b0;
    logic [31:0] rnd = 32'h1234_5678;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (noise_en) begin
                rnd = rnd ^ (rnd << 13);
                rnd = rnd ^ (rnd >> 17);
                rnd = rnd ^ (rnd << 5);
                scan_tick   = rnd[0] | rnd[1];
                tester_tick = rnd[2];
                tester_bit  = rnd[5];
            end
        end
    end

    // monitor with reference register
    logic [W-1:0] mdl = SEED;
    int mism = 0, shifts = 0, reseeds = 0, caps = 0, illegal = 0, gate_err = 0;
    logic [2:0] prev_ph = 3'd0;
    logic [2:0] first_ph = 3'd0;
    bit await_first = 1'b0;

    function automatic bit legal(input logic [2:0] a, input logic [2:0] b);
        if (a == b) return 1'b1;
        case (a)
            3'd0, 3'd5: return (b == 3'd1 || b == 3'd2 || b == 3'd5);
            3'd1:       return (b == 3'd4);
            3'd2:       return (b == 3'd3);
            3'd3:       return (b == 3'd4);
            3'd4:       return (b == 3'd1 || b == 3'd2 || b == 3'd5);
            default:    return 1'b0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (await_first) begin
                first_ph = phase;
                await_first = 1'b0;
            end
            if (!legal(prev_ph, phase)) illegal++;
            if (scan_shift) begin
                if (!scan_tick || !(phase == 3'd1 || phase == 3'd3)) gate_err++;
                if (scan_out != mdl[0]) mism++;
                mdl = mstep(mdl, 1'b0);
                shifts++;
            end else if (phase == 3'd2 && tester_tick) begin
                mdl = mstep(mdl, tester_bit);
                reseeds++;
            end
            if ((phase == 3'd0 || phase == 3'd5) && start) begin
                mdl = SEED;
                await_first = 1'b1;
            end
            if (capture) caps++;
            prev_ph = phase;
        end
    end

    task automatic clear_mon();
        mism = 0; shifts = 0; reseeds = 0; caps = 0; illegal = 0; gate_err = 0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        chk(ok, req, "run reached DONE", longint'(done), 1);
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk(phase == 3'd0 && !scan_shift && !capture && !done && pattern_cnt == 0,
            "R1", "state in reset", {phase, scan_shift, capture, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(phase == 3'd0 && !scan_shift && pattern_cnt == 0, "R1",
            "idle after reset", {phase, scan_shift}, 0);
    endtask

    task automatic run_and_check(input int p, input int d, input int exp_first,
                                 input bit change_counts);
        bit ok;
        @(posedge clk); #1;
        clear_mon();
        prng_count = CW'(p);
        det_count  = CW'(d);
        noise_en   = 1'b1;
        pulse_start();
        if (change_counts) begin
            repeat (3) @(posedge clk);
            #1 prng_count = CW'(7); det_count = CW'(9);
        end
        wait_done("R10", ok);
        chk(pattern_cnt == (p + d), "R10", "pattern_cnt at DONE", pattern_cnt, p + d);
        if (change_counts)
            chk(pattern_cnt == (p + d), "R11", "counts sampled at start only", pattern_cnt, p + d);
        chk(caps == (p + d), "R6", "capture pulses", caps, p + d);
        chk(shifts == (p + d) * M, "R3", "scan shifts (R5 load length)", shifts, (p + d) * M);
        chk(reseeds == d * N, "R4", "injections per run", reseeds, d * N);
        chk(mism == 0, "R9", "scan stream vs model (R5 R7)", mism, 0);
        chk(illegal == 0, "R6", "phase order", illegal, 0);
        chk(gate_err == 0, "R4", "shift only on scan_tick in PRNG/LOAD (R3)", gate_err, 0);
        chk(first_ph == 3'(exp_first), "R2", "first phase after start", first_ph, exp_first);
        repeat (12) @(negedge clk);
        chk(done && phase == 3'd5 && pattern_cnt == (p + d), "R10", "DONE holds",
            {phase, done}, {3'd5, 1'b1});
        noise_en = 1'b0;
    endtask

    task automatic t_zero();
        @(posedge clk); #1;
        prng_count = '0; det_count = '0;
        pulse_start();
        repeat (2) @(negedge clk);
        chk(done && phase == 3'd5 && pattern_cnt == 0, "R2", "zero counts go to DONE",
            {phase, pattern_cnt}, {3'd5, 13'd0});
    endtask

    task automatic full_reseed_to(input logic [W-1:0] target, inout logic [W-1:0] ms);
        bit seen = 1'b0;
        logic [W-1:0] got = '0;
        int j = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (f_phase == 3'd2) begin seen = 1'b1; break; end
        end
        chk(seen, "R8", "full-width instance reached RESEED", f_phase, 2);
        for (int k = 0; k < W; k++) begin
            @(posedge clk); #1;
            f_tick = 1'b1;
            f_bit  = (^(ms & TAPS)) ^ target[k];
            ms     = {target[k], ms[W-1:1]};
        end
        @(posedge clk); #1 f_tick = 1'b0;
        for (int i = 0; i < 200 && j < W; i++) begin
            @(negedge clk);
            if (f_shift) begin got[j] = f_out; j++; end
        end
        chk(got == target, "R8", "load stream equals forced state", got, target);
        for (int k = 0; k < W; k++) ms = mstep(ms, 1'b0);
    endtask

    task automatic t_full();
        logic [W-1:0] ms = SEED;
        bit ok = 1'b0;
        @(posedge clk); #1 f_start = 1'b1;
        @(posedge clk); #1 f_start = 1'b0;
        for (int k = 0; k < W; k++) ms = mstep(ms, 1'b0);
        full_reseed_to(16'h5A3C, ms);
        full_reseed_to(16'h0001, ms);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (f_done) begin ok = 1'b1; break; end
        end
        chk(ok && f_cnt == 3, "R8", "full-width run pattern count", f_cnt, 3);
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        run_and_check(2, 3, 1, 1'b0);
        run_and_check(0, 2, 2, 1'b0);
        run_and_check(3, 0, 1, 1'b0);
        run_and_check(1, 2, 1, 1'b1);
        t_zero();
        t_full();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule